// File: doc/BRIEF.md
# Word FIFO With Threshold Flags

This block is a word-wide staging buffer that sits between a bus-side register port and the data path of a memory-card host. The card side pulls words from it when sending and pushes words into it when receiving. A level input enables the data path. On the cycle it rises, the block latches the direction and the number of words the transfer will move. While the level is low, the buffer is emptied and all status is cleared.

Software or a DMA engine paces itself from level flags that are defined at the half-depth mark. There is an empty flag and a half-empty flag when sending, and a half-full flag and a data-available flag when receiving. Two request outputs serve a DMA engine. One asks for a burst of half the depth. The other asks for a shorter final burst once the words still owed by the bus fall below half depth. The bus side accepts only whole 32-bit words. Card-side requests that find the buffer empty (sending) or full (receiving) raise sticky error flags. A down-counter reports how many words of the programmed length have yet to cross the card side.

Top module: `wfifo_thresh`

## Requirements
- R1: After reset, both active bits, all flags, both error flags, both request outputs and the remaining count are 0.
- R2: When `path_en` rises, the next cycle shows exactly one active bit: `rx_active` if `dir_rx` was 1 at the rise, else `tx_active`. The remaining count then equals `xfer_words`. No transfer is accepted in the rise cycle.
- R3: Words leave in the order they entered, and up to DEPTH words are held. A push into a full buffer in the sending direction is dropped. `card_rdata` and `bus_rdata` show the oldest word.
- R4: While sending, `tx_empty` is 1 exactly when the level is 0, and `tx_half_empty` is 1 exactly when at least DEPTH/2 entries are free.
- R5: While receiving, `rx_half_full` is 1 exactly when the level is at least DEPTH/2, and `rx_avail` is 1 exactly when the level is at least 1.
- R6: A bus write or read whose byte enables are not all ones (4'b1111) has no effect. A bus access in the wrong direction, or while the data path is inactive, also has no effect.
- R7: Each word that crosses the card side lowers the remaining count by one. The count stops at 0.
- R8: While sending, a `card_req` with an empty buffer sets `tx_underrun`, which stays set. The remaining count and the level do not change.
- R9: While receiving, a `card_vld` with a full buffer sets `rx_overrun`, which stays set. The word is dropped, and the remaining count does not change.
- R10: `burst_req` is 1 when the words owed by the bus are at least DEPTH/2 and a half-depth burst fits. When sending, the words owed are the remaining count minus the level (floored at 0), and a burst fits when at least DEPTH/2 entries are free. When receiving, the words owed are the remaining count plus the level, and a burst fits when the level is at least DEPTH/2.
- R11: `last_req` is 1 when the owed words (as in R10) are between 1 and DEPTH/2-1 and the whole tail fits. When sending, the tail fits if the free entries are at least the owed words. When receiving, it fits if the level equals the owed words. `last_req` and `burst_req` are never both 1.
- R12: With `path_en` low, the next cycle shows an empty buffer, both active bits and both error flags cleared, and a remaining count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_en | input | 1 | Data path enable (level); rising edge starts a transfer |
| dir_rx | input | 1 | Direction at start: 1 receive, 0 send |
| xfer_words | input | LEN_W | Transfer length in words, latched at start |
| bus_wr | input | 1 | Bus write strobe (sending direction) |
| bus_rd | input | 1 | Bus read strobe (receiving direction) |
| bus_be | input | WIDTH/8 | Bus byte enables; only all ones is accepted |
| bus_wdata | input | WIDTH | Bus write word |
| bus_rdata | output | WIDTH | Oldest word, for bus reads |
| card_req | input | 1 | Card side takes a word (sending) |
| card_rdata | output | WIDTH | Oldest word, for the card side |
| card_vld | input | 1 | Card side delivers a word (receiving) |
| card_wdata | input | WIDTH | Word from the card side |
| tx_active | output | 1 | Sending transfer in progress |
| rx_active | output | 1 | Receiving transfer in progress |
| tx_empty | output | 1 | Sending and buffer empty |
| tx_half_empty | output | 1 | Sending and at least half the entries free |
| rx_half_full | output | 1 | Receiving and at least half the entries used |
| rx_avail | output | 1 | Receiving and at least one word present |
| burst_req | output | 1 | Half-depth DMA burst request |
| last_req | output | 1 | Final short DMA burst request |
| tx_underrun | output | 1 | Sticky send underrun |
| rx_overrun | output | 1 | Sticky receive overrun |
| rem_words | output | LEN_W | Words still to cross the card side |

## Verification
The bench sweeps the level through every value from empty to full in both directions and compares each flag and request against values it works out from the level and the remaining count. A design that placed the threshold one entry off would toggle the half flags or `burst_req` at the wrong step. Pushes into a full buffer, pulls from an empty one and partial-byte bus accesses are all driven, and the bench then checks that no word appears or disappears in the order check. A design with a wrong guard would therefore corrupt the data sequence or move the remaining count. The tail cases probe the count stopping at zero and `last_req` rising only once the full tail sits in the buffer; a design that ignored these would ask for a burst the bus cannot complete.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

  typedef enum logic {
    DIR_SEND = 1'b0,
    DIR_RECV = 1'b1
  } xfer_dir_e;

  // Words the bus side must still move for the transfer to complete.
  function automatic int unsigned owed_words(input logic recv,
                                             input int unsigned rem,
                                             input int unsigned lvl);
    if (recv) return rem + lvl;
    if (rem > lvl) return rem - lvl;
    return 0;
  endfunction

  // Pointer step with wrap at an arbitrary depth.
  function automatic int unsigned ptr_step(input int unsigned p,
                                           input int unsigned depth);
    if (p == depth - 1) return 0;
    return p + 1;
  endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW-1:0]    wr_nxt, rd_nxt;

  assign wr_nxt = AW'(wfifo_pkg::ptr_step(32'(wr_ptr), DEPTH));
  assign rd_nxt = AW'(wfifo_pkg::ptr_step(32'(rd_ptr), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_en,
  input  logic             dir_rx,
  input  logic [LEN_W-1:0] xfer_words,
  input  logic             card_move,
  input  logic             und_evt,
  input  logic             ovr_evt,
  output logic             act,
  output wfifo_pkg::xfer_dir_e dir_q,
  output logic [LEN_W-1:0] rem,
  output logic             underrun,
  output logic             overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      dir_q    <= wfifo_pkg::DIR_SEND;
      rem      <= '0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else if (!path_en) begin
      act      <= 1'b0;
      rem      <= '0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else if (!act) begin
      act      <= 1'b1;
      dir_q    <= dir_rx ? wfifo_pkg::DIR_RECV : wfifo_pkg::DIR_SEND;
      rem      <= xfer_words;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (card_move && rem != '0) rem <= rem - LEN_W'(1);
      if (und_evt) underrun <= 1'b1;
      if (ovr_evt) overrun  <= 1'b1;
    end
  end
endmodule

// File: rtl/wfifo_flags.sv
module wfifo_flags #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic             tx_act,
  input  logic             rx_act,
  input  logic [CW-1:0]    level,
  input  logic [LEN_W-1:0] rem,
  output logic             tx_empty,
  output logic             tx_half_empty,
  output logic             rx_half_full,
  output logic             rx_avail,
  output logic             burst_req,
  output logic             last_req
);
  int unsigned lv, rv, free_n, owed;
  logic        fits_burst, fits_tail;

  always_comb begin
    lv     = 32'(level);
    rv     = 32'(rem);
    free_n = DEPTH - lv;
    owed   = wfifo_pkg::owed_words(rx_act, rv, lv);

    tx_empty      = tx_act && (lv == 0);
    tx_half_empty = tx_act && (free_n >= HALF);
    rx_half_full  = rx_act && (lv >= HALF);
    rx_avail      = rx_act && (lv != 0);

    fits_burst = rx_act ? (lv >= HALF) : (free_n >= HALF);
    fits_tail  = rx_act ? (lv == owed) : (free_n >= owed);

    burst_req = (tx_act || rx_act) && (owed >= HALF) && fits_burst;
    last_req  = (tx_act || rx_act) && (owed != 0) && (owed < HALF) && fits_tail;
  end
endmodule

// File: rtl/wfifo_thresh.sv
module wfifo_thresh #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LEN_W = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BEW  = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_en,
  input  logic             dir_rx,
  input  logic [LEN_W-1:0] xfer_words,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BEW-1:0]   bus_be,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             card_req,
  output logic [WIDTH-1:0] card_rdata,
  input  logic             card_vld,
  input  logic [WIDTH-1:0] card_wdata,
  output logic             tx_active,
  output logic             rx_active,
  output logic             tx_empty,
  output logic             tx_half_empty,
  output logic             rx_half_full,
  output logic             rx_avail,
  output logic             burst_req,
  output logic             last_req,
  output logic             tx_underrun,
  output logic             rx_overrun,
  output logic [LEN_W-1:0] rem_words
);
  localparam logic [CW-1:0] FULL_LV = CW'(DEPTH);

  logic                 act;
  wfifo_pkg::xfer_dir_e dir_q;
  logic [CW-1:0]        level;
  logic [WIDTH-1:0]     head;
  logic                 whole_word, is_full, is_empty, flush;
  logic                 bus_push, bus_pop, card_pop, card_push;
  logic                 push_any, pop_any, card_move, und_evt, ovr_evt;
  logic [WIDTH-1:0]     push_data;

  assign tx_active  = act && (dir_q == wfifo_pkg::DIR_SEND);
  assign rx_active  = act && (dir_q == wfifo_pkg::DIR_RECV);
  assign whole_word = &bus_be;
  assign is_full    = (level == FULL_LV);
  assign is_empty   = (level == '0);
  assign flush      = !path_en;

  assign bus_push  = tx_active && bus_wr && whole_word && !is_full;
  assign bus_pop   = rx_active && bus_rd && whole_word && !is_empty;
  assign card_pop  = tx_active && card_req && !is_empty;
  assign card_push = rx_active && card_vld && !is_full;
  assign und_evt   = tx_active && card_req && is_empty;
  assign ovr_evt   = rx_active && card_vld && is_full;

  assign push_any  = bus_push || card_push;
  assign pop_any   = bus_pop || card_pop;
  assign card_move = card_pop || card_push;
  assign push_data = rx_active ? card_wdata : bus_wdata;

  wfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push_any),
    .push_data (push_data),
    .pop       (pop_any),
    .head      (head),
    .level     (level)
  );

  wfifo_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_en    (path_en),
    .dir_rx     (dir_rx),
    .xfer_words (xfer_words),
    .card_move  (card_move),
    .und_evt    (und_evt),
    .ovr_evt    (ovr_evt),
    .act        (act),
    .dir_q      (dir_q),
    .rem        (rem_words),
    .underrun   (tx_underrun),
    .overrun    (rx_overrun)
  );

  wfifo_flags #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_flags (
    .tx_act        (tx_active),
    .rx_act        (rx_active),
    .level         (level),
    .rem           (rem_words),
    .tx_empty      (tx_empty),
    .tx_half_empty (tx_half_empty),
    .rx_half_full  (rx_half_full),
    .rx_avail      (rx_avail),
    .burst_req     (burst_req),
    .last_req      (last_req)
  );

  assign bus_rdata  = head;
  assign card_rdata = head;

endmodule

// File: rtl/wfifo_thresh_chk.sv
module wfifo_thresh_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LEN_W = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BEW  = WIDTH / 8,
  localparam int HALF = DEPTH / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             path_en,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [BEW-1:0]   bus_be,
  input logic [CW-1:0]    level,
  input logic             push_any,
  input logic             pop_any,
  input logic             flush,
  input logic             card_move,
  input logic             und_evt,
  input logic             ovr_evt,
  input logic             tx_active,
  input logic             rx_active,
  input logic             tx_underrun,
  input logic             rx_overrun,
  input logic             tx_half_empty,
  input logic             rx_half_full,
  input logic             rx_avail,
  input logic             burst_req,
  input logic             last_req,
  input logic [LEN_W-1:0] rem_words
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> level == $past(level) + CW'($past(push_any)) - CW'($past(pop_any)));

  assert_one_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_active, rx_active}));

  assert_half_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half_empty |-> (tx_active && level <= CW'(DEPTH - HALF)));

  assert_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half_full |-> rx_avail);

  assert_word_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !(&bus_be) && !card_move && path_en) |=> $stable(level));

  assert_rem_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (card_move && path_en && rem_words != '0) |=> rem_words == $past(rem_words) - LEN_W'(1));

  assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (und_evt && path_en) |=> tx_underrun);

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && path_en) |=> rx_overrun);

  assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_req && last_req));

  assert_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |=> (level == '0 && !tx_active && !rx_active &&
                  !tx_underrun && !rx_overrun && rem_words == '0));
endmodule

bind wfifo_thresh wfifo_thresh_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_wfifo_thresh.sv
module sim_wfifo_thresh;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, path_en, dir_rx, bus_wr, bus_rd, card_req, card_vld;
  logic [LEN_W-1:0] xfer_words, rem_words;
  logic [3:0]       bus_be;
  logic [31:0]      bus_wdata, bus_rdata, card_rdata, card_wdata;
  logic tx_active, rx_active, tx_empty, tx_half_empty, rx_half_full, rx_avail;
  logic burst_req, last_req, tx_underrun, rx_overrun;

  wfifo_thresh #(.DEPTH(DEPTH), .WIDTH(32), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .dir_rx(dir_rx),
    .xfer_words(xfer_words), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_req(card_req),
    .card_rdata(card_rdata), .card_vld(card_vld), .card_wdata(card_wdata),
    .tx_active(tx_active), .rx_active(rx_active), .tx_empty(tx_empty),
    .tx_half_empty(tx_half_empty), .rx_half_full(rx_half_full), .rx_avail(rx_avail),
    .burst_req(burst_req), .last_req(last_req), .tx_underrun(tx_underrun),
    .rx_overrun(rx_overrun), .rem_words(rem_words)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] q[$];
  int m_rem = 0;
  bit m_act = 0, m_rx = 0, m_und = 0, m_ovr = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_state(string where);
    int lvl = q.size();
    int free_n = DEPTH - lvl;
    int owed;
    logic [9:0] e, a;
    if (m_rx) owed = m_rem + lvl;
    else owed = (m_rem > lvl) ? m_rem - lvl : 0;
    e[9] = m_act && !m_rx;
    e[8] = m_act && m_rx;
    e[7] = m_act && !m_rx && lvl == 0;
    e[6] = m_act && !m_rx && free_n >= HALF;
    e[5] = m_act && m_rx && lvl >= HALF;
    e[4] = m_act && m_rx && lvl > 0;
    e[3] = m_act && owed >= HALF && (m_rx ? lvl >= HALF : free_n >= HALF);
    e[2] = m_act && owed > 0 && owed < HALF && (m_rx ? lvl == owed : free_n >= owed);
    e[1] = m_und;
    e[0] = m_ovr;
    a = {tx_active, rx_active, tx_empty, tx_half_empty, rx_half_full, rx_avail,
         burst_req, last_req, tx_underrun, rx_overrun};
    check({where, " flags R2 R4 R5 R8 R9 R10 R11"}, 32'(a), 32'(e));
    check({where, " remaining R7"}, 32'(rem_words), 32'(m_rem));
  endtask

  task automatic bus_write(logic [31:0] d, logic [3:0] be);
    bus_wr = 1'b1; bus_wdata = d; bus_be = be;
    step();
    bus_wr = 1'b0; bus_be = 4'hF;
    if (m_act && !m_rx && be == 4'hF && q.size() < DEPTH) q.push_back(d);
    chk_state(be == 4'hF ? "bus write R3" : "partial write R6");
  endtask

  task automatic bus_read(logic [3:0] be);
    if (m_act && m_rx && q.size() > 0) check("bus read order R3", bus_rdata, q[0]);
    bus_rd = 1'b1; bus_be = be;
    step();
    bus_rd = 1'b0; bus_be = 4'hF;
    if (m_act && m_rx && be == 4'hF && q.size() > 0) void'(q.pop_front());
    chk_state(be == 4'hF ? "bus read R3" : "partial read R6");
  endtask

  task automatic card_pull();
    if (m_act && !m_rx && q.size() > 0) check("card pull order R3", card_rdata, q[0]);
    card_req = 1'b1;
    step();
    card_req = 1'b0;
    if (m_act && !m_rx) begin
      if (q.size() > 0) begin
        void'(q.pop_front());
        if (m_rem > 0) m_rem--;
      end else m_und = 1;
    end
    chk_state("card pull R8");
  endtask

  task automatic card_give(logic [31:0] d);
    card_vld = 1'b1; card_wdata = d;
    step();
    card_vld = 1'b0;
    if (m_act && m_rx) begin
      if (q.size() < DEPTH) begin
        q.push_back(d);
        if (m_rem > 0) m_rem--;
      end else m_ovr = 1;
    end
    chk_state("card give R9");
  endtask

  task automatic start(bit rx, int n);
    path_en = 1'b1; dir_rx = rx; xfer_words = LEN_W'(n);
    step();
    m_act = 1; m_rx = rx; m_rem = n; m_und = 0; m_ovr = 0;
    chk_state("start R2");
  endtask

  task automatic stop();
    path_en = 1'b0;
    step();
    q.delete();
    m_act = 0; m_rem = 0; m_und = 0; m_ovr = 0;
    chk_state("disable R12");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog R1: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; path_en = 1'b0; dir_rx = 1'b0; xfer_words = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = 4'hF; bus_wdata = '0;
    card_req = 1'b0; card_vld = 1'b0; card_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_state("reset R1");
    bus_write(32'hDEAD_0001, 4'hF);   // inactive path: ignored (R6)

    // Send direction: fill sweep, overfill, drain, underrun
    start(1'b0, 40);
    bus_write(32'hAAAA_0000, 4'b0111);
    bus_write(32'hAAAA_0001, 4'b1110);
    card_give(32'hBBBB_0000);         // wrong direction for the card side
    for (int i = 0; i <= DEPTH; i++) bus_write(32'h1000_0000 + 32'(i), 4'hF);
    for (int i = 0; i < DEPTH; i++) card_pull();
    card_pull();
    card_pull();
    stop();

    // Send tail: last burst and count floor
    start(1'b0, 5);
    for (int i = 0; i < 5; i++) bus_write(32'h2000_0000 + 32'(i), 4'hF);
    for (int i = 0; i < 5; i++) card_pull();
    bus_write(32'h2000_00FF, 4'hF);
    card_pull();
    stop();

    // Receive direction: fill sweep, overrun, drain, tail
    start(1'b1, 20);
    bus_read(4'hF);
    bus_write(32'hCCCC_0000, 4'hF);   // wrong direction for the bus side
    for (int i = 0; i <= DEPTH; i++) card_give(32'h3000_0000 + 32'(i));
    bus_read(4'b0011);
    for (int i = 0; i < DEPTH; i++) bus_read(4'hF);
    for (int i = 0; i < 4; i++) card_give(32'h4000_0000 + 32'(i));
    bus_read(4'hF);
    stop();

    // Short receive transfer, then disable with data held
    start(1'b1, 3);
    for (int i = 0; i < 3; i++) card_give(32'h5000_0000 + 32'(i));
    card_give(32'h5000_00FF);
    stop();

    summary();
    $finish;
  end
endmodule